// File: doc/BRIEF.md
# DMA Bus-Cycle Sequencer

This block sequences the bus cycles of one DMA channel. A device request takes the idle sequencer to a hold phase, where it asks the processor for the bus and waits for the grant. It then runs transfers. A transfer starts with an optional state that re-drives the middle address byte for an external latch. It then drives the low address byte and the device acknowledge, and places the read and write command strobes for memory and I/O.

The sequencer steps once per DMA clock. The DMA clock is a clock enable at half the bus clock rate, supplied by the surrounding logic. Two mode bits shape the cycle. The compressed mode drops the separate read state, so a plain transfer takes two DMA clocks instead of three. The extended-write mode raises the write strobe one state early. The two modes cannot be combined: that setting is flagged and requests are refused. A low READY stretches the cycle with wait states. After each transfer the sequencer either starts the next one directly or releases the bus. The address unit beside it supplies the address bytes, the middle-byte-update flag and the terminal-count flag.

Top module: `dma_cycle_seq`

## Requirements
- R1: After reset, hold, aen, adstb, dack, dataOe, xferDone, modeError and all four command strobes are low.
- R2: In idle, a high dreq moves the sequencer to the hold phase at the next DMA clock. In that phase hold is high and aen and dack are low. It stays there, for as many DMA clocks as it takes, until hlda is high.
- R3: The state changes only on bus clock edges where dmaClkEn is high. With dmaClkEn low, all outputs hold their values.
- R4: The middle-byte state occurs only when needMidUpdate is high at the transition into a transfer. In it, aen and dataOe are high, dack is low and dataOut equals addrMid. In the following state dataOe stays high with addrMid, and adstb pulses for that one DMA clock. A transfer without the middle-byte state never raises adstb or dataOe.
- R5: From the address state to the end of the transfer, dack, aen and hold are high and addrOut equals addrLow.
- R6: With READY high, a transfer lasts 3 DMA clocks with compressed off and 2 with compressed on, plus 1 when the middle-byte state is present.
- R7: The read strobe is high for the last two states and any wait states between them when compressed is off. With compressed on, it is high in the final state only. With dirMemToIo = 1, the read goes on memRd and the write on ioWr. With dirMemToIo = 0, the read goes on ioRd and the write on memWr. The other two strobes stay low.
- R8: The write strobe is high in the final state only. With extWrite set, it is also high from the start of the read state and through any wait states.
- R9: READY is sampled at the end of the state before the final state: the read state normally, the address state when compressed. It is also sampled at the end of each wait state. Each low sample adds one DMA clock, during which the strobes keep their levels. In compressed mode no strobe is high during a wait state.
- R10: If dreq is high and termCount is low at the end of the final state, the next transfer begins at once, at the middle-byte or address state, with hold staying high.
- R11: If termCount is high or dreq is low at the end of the final state, the sequencer returns to idle and hold falls.
- R12: With compressed and extWrite both set, modeError is high and a request in idle is ignored: hold stays low.
- R13: xferDone is high exactly during the final state of each transfer, once per transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| dmaClkEn | input | 1 | DMA clock enable, high one bus clock in two |
| dreq | input | 1 | Device request |
| hlda | input | 1 | Processor hold acknowledge |
| ready | input | 1 | Slow-device ready, low inserts waits |
| compressed | input | 1 | Compressed timing mode |
| extWrite | input | 1 | Extended write mode |
| dirMemToIo | input | 1 | 1: memory read, I/O write; 0: I/O read, memory write |
| needMidUpdate | input | 1 | Address unit requests a middle-byte re-latch |
| termCount | input | 1 | Address unit signals the last transfer |
| addrLow | input | BYTE_W | Low address byte |
| addrMid | input | BYTE_W | Middle address byte |
| hold | output | 1 | Bus hold request |
| aen | output | 1 | Address enable |
| adstb | output | 1 | Address latch strobe |
| dack | output | 1 | Device acknowledge |
| memRd | output | 1 | Memory read command |
| memWr | output | 1 | Memory write command |
| ioRd | output | 1 | I/O read command |
| ioWr | output | 1 | I/O write command |
| addrOut | output | BYTE_W | Low address byte out |
| dataOut | output | BYTE_W | Middle address byte on the data pins |
| dataOe | output | 1 | Data pin drive enable |
| xferDone | output | 1 | Final state of a transfer |
| modeError | output | 1 | Illegal mode combination |

## Verification
The assertions take the mode bits to be steady for the whole of a transfer. They also take dmaClkEn to be a clean enable that no logic derives from the sequencer's outputs. If the modes changed mid-cycle, the strobe and rejection checks would describe a cycle that never started. The bench sets compressed, extWrite and the direction only while the sequencer is idle. It drives dmaClkEn as a strict one-in-two pulse from a single task, and it changes dreq, hlda, ready and termCount only between DMA clocks.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_MID,
    ST_ADDR,
    ST_RD,
    ST_WAIT,
    ST_FIN
  } seqState_t;

  typedef struct packed {
    logic holdReq;
    logic addrEn;
    logic devAck;
    logic midDrive;
    logic midStrobe;
    logic rdCmd;
    logic wrCmd;
    logic done;
  } seqStrobe_t;

endpackage

// File: rtl/dmaseq_ctrl.sv
module dmaseq_ctrl
  import dmaseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       dreq,
  input  logic       hlda,
  input  logic       ready,
  input  logic       compressed,
  input  logic       extWrite,
  input  logic       needMid,
  input  logic       termCount,
  output seqStrobe_t strb,
  output logic       modeError
);

  seqState_t state, stateNext;
  logic      fromMid;
  logic      inStretch;
  seqState_t xferEntry;

  assign modeError = compressed & extWrite;
  assign inStretch = (state == ST_RD) || (state == ST_WAIT);
  assign xferEntry = needMid ? ST_MID : ST_ADDR;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (dreq && !modeError) stateNext = ST_REQ;
      ST_REQ:  if (hlda) stateNext = xferEntry;
      ST_MID:  stateNext = ST_ADDR;
      ST_ADDR: begin
        if (!compressed)  stateNext = ST_RD;
        else if (ready)   stateNext = ST_FIN;
        else              stateNext = ST_WAIT;
      end
      ST_RD, ST_WAIT: stateNext = ready ? ST_FIN : ST_WAIT;
      ST_FIN: stateNext = (dreq && !termCount) ? xferEntry : ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      fromMid <= 1'b0;
    end else if (tick) begin
      state   <= stateNext;
      fromMid <= (state == ST_MID);
    end
  end

  always_comb begin
    strb           = '0;
    strb.holdReq   = (state != ST_IDLE);
    strb.addrEn    = (state != ST_IDLE) && (state != ST_REQ);
    strb.devAck    = strb.addrEn && (state != ST_MID);
    strb.midStrobe = (state == ST_ADDR) && fromMid;
    strb.midDrive  = (state == ST_MID) || strb.midStrobe;
    strb.rdCmd     = (state == ST_FIN) || (!compressed && inStretch);
    strb.wrCmd     = (state == ST_FIN) || (extWrite && inStretch);
    strb.done      = (state == ST_FIN);
  end

  assert_gated_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(state));

  assert_strobe_after_mid_R4: assert property (@(posedge clk) disable iff (!rstN)
    (tick && state == ST_MID) |=> strb.midStrobe);

  assert_ack_under_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.devAck |-> (strb.holdReq && strb.addrEn));

  assert_compressed_read_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdCmd && compressed) |-> (state == ST_FIN));

  assert_release_R11: assert property (@(posedge clk) disable iff (!rstN)
    (tick && state == ST_FIN && termCount) |=> (state == ST_IDLE));

  assert_reject_R12: assert property (@(posedge clk) disable iff (!rstN)
    (tick && state == ST_IDLE && compressed && extWrite) |=> (state == ST_IDLE));

endmodule

// File: rtl/dmaseq_dp.sv
module dmaseq_dp
  import dmaseq_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  seqStrobe_t        strb,
  input  logic              dirMemToIo,
  input  logic [BYTE_W-1:0] addrLow,
  input  logic [BYTE_W-1:0] addrMid,
  output logic              hold,
  output logic              aen,
  output logic              adstb,
  output logic              dack,
  output logic              memRd,
  output logic              memWr,
  output logic              ioRd,
  output logic              ioWr,
  output logic [BYTE_W-1:0] addrOut,
  output logic [BYTE_W-1:0] dataOut,
  output logic              dataOe,
  output logic              xferDone
);

  assign hold     = strb.holdReq;
  assign aen      = strb.addrEn;
  assign adstb    = strb.midStrobe;
  assign dack     = strb.devAck;
  assign xferDone = strb.done;

  assign memRd = strb.rdCmd &  dirMemToIo;
  assign ioWr  = strb.wrCmd &  dirMemToIo;
  assign ioRd  = strb.rdCmd & ~dirMemToIo;
  assign memWr = strb.wrCmd & ~dirMemToIo;

  assign addrOut = strb.devAck   ? addrLow : '0;
  assign dataOe  = strb.midDrive;
  assign dataOut = strb.midDrive ? addrMid : '0;

endmodule

// File: rtl/dma_cycle_seq.sv
module dma_cycle_seq
  import dmaseq_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dmaClkEn,
  input  logic              dreq,
  input  logic              hlda,
  input  logic              ready,
  input  logic              compressed,
  input  logic              extWrite,
  input  logic              dirMemToIo,
  input  logic              needMidUpdate,
  input  logic              termCount,
  input  logic [BYTE_W-1:0] addrLow,
  input  logic [BYTE_W-1:0] addrMid,
  output logic              hold,
  output logic              aen,
  output logic              adstb,
  output logic              dack,
  output logic              memRd,
  output logic              memWr,
  output logic              ioRd,
  output logic              ioWr,
  output logic [BYTE_W-1:0] addrOut,
  output logic [BYTE_W-1:0] dataOut,
  output logic              dataOe,
  output logic              xferDone,
  output logic              modeError
);

  seqStrobe_t strb;

  dmaseq_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .tick      (dmaClkEn),
    .dreq      (dreq),
    .hlda      (hlda),
    .ready     (ready),
    .compressed(compressed),
    .extWrite  (extWrite),
    .needMid   (needMidUpdate),
    .termCount (termCount),
    .strb      (strb),
    .modeError (modeError)
  );

  dmaseq_dp #(.BYTE_W(BYTE_W)) dp_i (
    .strb      (strb),
    .dirMemToIo(dirMemToIo),
    .addrLow   (addrLow),
    .addrMid   (addrMid),
    .hold      (hold),
    .aen       (aen),
    .adstb     (adstb),
    .dack      (dack),
    .memRd     (memRd),
    .memWr     (memWr),
    .ioRd      (ioRd),
    .ioWr      (ioWr),
    .addrOut   (addrOut),
    .dataOut   (dataOut),
    .dataOe    (dataOe),
    .xferDone  (xferDone)
  );

endmodule

// File: tb/dma_cycle_seq_tb.sv
module dma_cycle_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int BYTE_W     = 8;

  logic clk = 1'b0;
  logic rstN, dmaClkEn, dreq, hlda, ready, compressed, extWrite, dirMemToIo;
  logic needMidUpdate, termCount;
  logic [BYTE_W-1:0] addrLow, addrMid, addrOut, dataOut;
  logic hold, aen, adstb, dack, memRd, memWr, ioRd, ioWr, dataOe, xferDone, modeError;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_cycle_seq #(.BYTE_W(BYTE_W)) dut_i (
    .clk(clk), .rstN(rstN), .dmaClkEn(dmaClkEn), .dreq(dreq), .hlda(hlda),
    .ready(ready), .compressed(compressed), .extWrite(extWrite),
    .dirMemToIo(dirMemToIo), .needMidUpdate(needMidUpdate), .termCount(termCount),
    .addrLow(addrLow), .addrMid(addrMid), .hold(hold), .aen(aen), .adstb(adstb),
    .dack(dack), .memRd(memRd), .memWr(memWr), .ioRd(ioRd), .ioWr(ioWr),
    .addrOut(addrOut), .dataOut(dataOut), .dataOe(dataOe), .xferDone(xferDone),
    .modeError(modeError)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic dmaStep();
    @(negedge clk) dmaClkEn = 1'b1;
    @(negedge clk) dmaClkEn = 1'b0;
  endtask

  // One transfer with termCount high; count per-DMA-clock strobe activity.
  task automatic runOne(input logic c, input logic e, input logic dir,
                        input logic nm, input int w);
    int lenCnt = 0, rdCnt = 0, wrCnt = 0, stbCnt = 0, oeCnt = 0, doneCnt = 0;
    int wrongCnt = 0, sampCnt = 0, addrBad = 0, midBad = 0, guard = 0;
    logic rdAny, wrAny;
    compressed = c; extWrite = e; dirMemToIo = dir; needMidUpdate = nm;
    termCount = 1'b1; ready = 1'b1; hlda = 1'b0; dreq = 1'b1;
    addrLow = 8'h5A ^ {7'd0, dir}; addrMid = 8'hC3 ^ {7'd0, nm};
    dmaStep();
    check(hold && !aen && !dack, "R2 hold phase", int'(hold), 1);
    hlda = 1'b1;
    dmaStep();
    while (aen && guard < 30) begin
      guard++;
      rdAny = memRd | ioRd;
      wrAny = memWr | ioWr;
      lenCnt++;
      rdCnt  += int'(rdAny);
      wrCnt  += int'(wrAny);
      stbCnt += int'(adstb);
      oeCnt  += int'(dataOe);
      doneCnt += int'(xferDone);
      wrongCnt += dir ? int'(ioRd | memWr) : int'(memRd | ioWr);
      if (dack && addrOut != addrLow) addrBad++;
      if (dataOe && dataOut != addrMid) midBad++;
      if (dack && !xferDone && (c || rdAny)) begin
        ready = (sampCnt >= w);
        sampCnt++;
      end else begin
        ready = 1'b1;
      end
      dmaStep();
    end
    hlda = 1'b0; dreq = 1'b0; ready = 1'b1;
    check(lenCnt == int'(nm) + (c ? 2 : 3) + w, "R6/R9 cycle length", lenCnt,
          int'(nm) + (c ? 2 : 3) + w);
    check(rdCnt == (c ? 1 : 2 + w), "R7 read strobe clocks", rdCnt, c ? 1 : 2 + w);
    check(wrCnt == (e ? 2 + w : 1), "R8 write strobe clocks", wrCnt, e ? 2 + w : 1);
    check(wrongCnt == 0, "R7 direction", wrongCnt, 0);
    check(stbCnt == int'(nm) && oeCnt == (nm ? 2 : 0), "R4 mid byte strobes",
          stbCnt * 10 + oeCnt, int'(nm) * 10 + (nm ? 2 : 0));
    check(addrBad == 0 && midBad == 0, "R5/R4 address bytes", addrBad + midBad, 0);
    check(doneCnt == 1, "R13 done once", doneCnt, 1);
    check(!hold, "R11 release on terminal count", int'(hold), 0);
  endtask

  // Step until the final state is visible.
  task automatic toFinal();
    for (int g = 0; g < 20 && !xferDone; g++) dmaStep();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFails++;
    nChecks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    rstN = 1'b0; dmaClkEn = 1'b0; dreq = 1'b0; hlda = 1'b0; ready = 1'b1;
    compressed = 1'b0; extWrite = 1'b0; dirMemToIo = 1'b1; needMidUpdate = 1'b0;
    termCount = 1'b0; addrLow = '0; addrMid = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!hold && !aen && !adstb && !dack && !dataOe && !xferDone && !modeError &&
          !memRd && !memWr && !ioRd && !ioWr, "R1 reset outputs", int'(hold), 0);

    // R3: no step without the enable
    dreq = 1'b1;
    repeat (5) @(negedge clk);
    check(!hold, "R3 gated by enable", int'(hold), 0);
    dmaStep();
    check(hold, "R3 step on enable", int'(hold), 1);
    repeat (3) @(negedge clk);
    check(hold && !aen, "R3 steady between enables", int'(aen), 0);
    // R2: waits in hold phase while hlda low
    repeat (4) dmaStep();
    check(hold && !aen && !dack, "R2 waits for hlda", int'(aen), 0);
    hlda = 1'b1; termCount = 1'b0;
    dmaStep();
    check(dack && aen && !dataOe, "R2 grant to address state", int'(dack), 1);

    // R10: back-to-back without re-entering hold phase
    toFinal();
    dmaStep();
    check(hold && dack && !memRd && !ioRd, "R10 next transfer direct", int'(dack), 1);
    needMidUpdate = 1'b1;
    toFinal();
    dmaStep();
    check(hold && aen && !dack && dataOe, "R10 next transfer via mid state",
          int'(dataOe), 1);
    needMidUpdate = 1'b0;
    // R11: dreq low ends
    toFinal();
    dreq = 1'b0;
    dmaStep();
    check(!hold && !aen, "R11 release on dreq low", int'(hold), 0);
    hlda = 1'b0;

    // R12: illegal mode combination
    compressed = 1'b1; extWrite = 1'b1; dreq = 1'b1;
    @(negedge clk);
    check(modeError, "R12 flag", int'(modeError), 1);
    repeat (3) dmaStep();
    check(!hold, "R12 request ignored", int'(hold), 0);
    dreq = 1'b0;
    dmaStep();

    // Sweep of modes, direction, mid update and wait count
    for (int m = 0; m < 3; m++)
      for (int d = 0; d < 2; d++)
        for (int n = 0; n < 2; n++)
          for (int w = 0; w < 3; w++)
            runOne(m == 1, m == 2, d[0], n[0], w);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule